// File: doc/BRIEF.md
# Keyed Unlock and Software Reset Guard

This block sits on a simple register bus and does two jobs. It keeps a set of critical registers elsewhere in the chip write-protected until software writes two magic key values, in a fixed order, to a dedicated key register. It also lets software reset the system. Software first arms a reset bit, which it can only do while the block is unlocked. It then reads that same register back, and the read fires the reset.

The `unlocked` output goes to the protected registers as their write enable. The `swrst_pulse` output is a one-cycle request to the system reset controller. When the request fires, the block clears its own arm bit and unlock state. It also sets a sticky software-reset flag that software can read later and clear.

Word addresses are parameters. With the defaults, the key register is at address 0, the reset-arm register at address 1 and the status register at address 2. Reads of any other address return 0. Reads are combinational: `bus_rdata` carries the value in the same cycle as `bus_rd`.

Top module: `keyed_reset_guard`

## Requirements
- R1: After `rst_n` is released, `unlocked` and `swrst_pulse` are 0, and reads of the arm register (address 1) and the status register (address 2) return 0. This holds even if the block was armed and unlocked before the reset.
- R2: A write of 0xAA996655 to the key register (address 0) while locked, followed by a write of 0x556699AA to the key register as the next bus access, sets `unlocked` to 1 in the cycle after the second write. Idle cycles between the two writes are allowed.
- R3: A write of any other value to the key register while locked, including one in place of either key, leaves the block locked with the sequence back at its start.
- R4: Between the two key writes, any other bus access returns the sequence to its start, so the following second-key write does not unlock. This covers a read of any address and a write to any other register.
- R5: While unlocked, a write of any value to the key register sets `unlocked` to 0 in the next cycle.
- R6: A write to the arm register while locked has no effect: a later read of the arm register returns 0 and raises no reset request.
- R7: While unlocked, a write to the arm register loads bit 0 of the write data into the arm bit. A read of the arm register returns the arm bit in bit 0, with all other bits 0.
- R8: A read of the arm register while the arm bit is 1 drives `swrst_pulse` high for exactly one cycle, starting in the cycle after the read.
- R9: A read of the arm register while the arm bit is 0 returns 0 and does not raise `swrst_pulse`.
- R10: When the reset request fires, the arm bit is cleared and the block is locked in that same cycle.
- R11: The reset request sets the software-reset flag, which reads as bit 0 of the status register. A status write with bit 0 = 1 clears the flag; a status write with bit 0 = 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Word address of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| unlocked | output | 1 | High while protected registers may be written |
| swrst_pulse | output | 1 | One-cycle software reset request |

## Verification
On every cycle, the embedded assertions check the following:
- the reset request lasts exactly one cycle;
- an armed read always fires the request, and an unarmed read never does;
- the arm bit never rises while the block is locked;
- the unlock state can only be entered through a second-key write that follows the first key;
- a key write always relocks an open block;
- the flag is set, and the block is locked and disarmed, whenever the request is high.

Only the bench's scenarios show the following:
- the exact key sequences that fail, such as an intervening read or arm write, or a wrong or repeated key;
- that idle cycles do not break the sequence;
- the read-back values;
- the write-one-to-clear behaviour of the flag;
- that a reset clears an armed, unlocked block.

// File: rtl/krg_pkg.sv
`timescale 1ns/1ps
package krg_pkg;

   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_HALF   = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_e;

   typedef struct packed {
      logic any;
      logic key_wr;
      logic arm_wr;
      logic arm_rd;
      logic stat_wr;
      logic stat_rd;
   } bus_hits_t;

endpackage

// File: rtl/krg_decode.sv
`timescale 1ns/1ps
module krg_decode
   import krg_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int KEY_ADDR  = 0,
   parameter int ARM_ADDR  = 1,
   parameter int STAT_ADDR = 2
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   output bus_hits_t         hits_o
);
   localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(KEY_ADDR);
   localparam logic [ADDR_W-1:0] A_ARM  = ADDR_W'(ARM_ADDR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

   logic at_key, at_arm, at_stat;

   always_comb begin
      at_key  = (addr_i == A_KEY);
      at_arm  = (addr_i == A_ARM);
      at_stat = (addr_i == A_STAT);
      hits_o.any     = wr_i | rd_i;
      hits_o.key_wr  = wr_i & at_key;
      hits_o.arm_wr  = wr_i & at_arm;
      hits_o.arm_rd  = rd_i & at_arm;
      hits_o.stat_wr = wr_i & at_stat;
      hits_o.stat_rd = rd_i & at_stat;
   end

   always_comb begin
      assert ($countones({at_key, at_arm, at_stat}) <= 1)
         else $error("decode: overlapping register addresses");
   end
endmodule

// File: rtl/krg_key_seq.sv
`timescale 1ns/1ps
module krg_key_seq
   import krg_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 32'hAA99_6655,
   parameter logic [DATA_W-1:0] KEY_SECOND = 32'h5566_99AA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_hits_t         hits_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              force_lock_i,
   output logic              unlocked_o
);
   key_state_e state_q, state_d;
   logic       first_ok, second_ok;

   always_comb begin
      first_ok  = hits_i.key_wr && (wdata_i == KEY_FIRST);
      second_ok = hits_i.key_wr && (wdata_i == KEY_SECOND);
      state_d   = state_q;
      if (force_lock_i) begin
         state_d = KS_LOCKED;
      end else begin
         unique case (state_q)
            KS_LOCKED: if (hits_i.key_wr) state_d = first_ok  ? KS_HALF : KS_LOCKED;
            KS_HALF:   if (hits_i.any)    state_d = second_ok ? KS_OPEN : KS_LOCKED;
            KS_OPEN:   if (hits_i.key_wr) state_d = KS_LOCKED;
            default:                      state_d = KS_LOCKED;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= KS_LOCKED;
      else        state_q <= state_d;
   end

   assign unlocked_o = (state_q == KS_OPEN);

   // R2: the open state is reached only by a second-key write after the first key
   a_r2_open_needs_sequence: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked_o) |-> $past(state_q == KS_HALF && hits_i.key_wr && wdata_i == KEY_SECOND));
   // R3: a key write that is not the second key never opens a locked block
   a_r3_wrong_key_stays_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != KS_OPEN && hits_i.key_wr && wdata_i != KEY_SECOND) |=> !unlocked_o);
   // R4: any other access in the half-open state drops back to locked
   a_r4_intervening_access: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == KS_HALF && hits_i.any && !hits_i.key_wr) |=> (state_q == KS_LOCKED));
   // R5: any key write relocks an open block
   a_r5_key_write_relocks: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == KS_OPEN && hits_i.key_wr) |=> !unlocked_o);
endmodule

// File: rtl/krg_arm_trig.sv
`timescale 1ns/1ps
module krg_arm_trig
   import krg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  bus_hits_t hits_i,
   input  logic      wbit0_i,
   input  logic      unlocked_i,
   output logic      armed_o,
   output logic      flag_o,
   output logic      fire_o,
   output logic      pulse_o
);
   logic arm_q, flag_q, pulse_q;

   assign fire_o = hits_i.arm_rd & arm_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q   <= 1'b0;
         flag_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= fire_o;
         if (fire_o) begin
            arm_q  <= 1'b0;
            flag_q <= 1'b1;
         end else begin
            if (hits_i.arm_wr && unlocked_i) arm_q  <= wbit0_i;
            if (hits_i.stat_wr && wbit0_i)   flag_q <= 1'b0;
         end
      end
   end

   assign armed_o = arm_q;
   assign flag_o  = flag_q;
   assign pulse_o = pulse_q;

   // R8: the request lasts exactly one cycle
   a_r8_pulse_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);
   // R8: a read of an armed register always fires on the next cycle
   a_r8_armed_read_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (hits_i.arm_rd && arm_q) |=> pulse_q);
   // R9: a read of an unarmed register never fires
   a_r9_unarmed_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (hits_i.arm_rd && !arm_q) |=> !pulse_q);
   // R6: arming is impossible while locked
   a_r6_locked_cannot_arm: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked_i |=> !$rose(arm_q));
   // R11: the flag is set whenever the request is high
   a_r11_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> flag_q);
endmodule

// File: rtl/keyed_reset_guard.sv
`timescale 1ns/1ps
module keyed_reset_guard
   import krg_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter int                ADDR_W     = 4,
   parameter int                KEY_ADDR   = 0,
   parameter int                ARM_ADDR   = 1,
   parameter int                STAT_ADDR  = 2,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 32'hAA99_6655,
   parameter logic [DATA_W-1:0] KEY_SECOND = 32'h5566_99AA,
   parameter bit                REG_READ   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              unlocked,
   output logic              swrst_pulse
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (DATA_W < 2) begin : g_chk_width
      $error("keyed_reset_guard: DATA_W must be at least 2");
   end
   if (KEY_FIRST == KEY_SECOND) begin : g_chk_keys
      $error("keyed_reset_guard: the two keys must differ");
   end
   if (KEY_ADDR == ARM_ADDR || KEY_ADDR == STAT_ADDR || ARM_ADDR == STAT_ADDR) begin : g_chk_map
      $error("keyed_reset_guard: register addresses must be distinct");
   end
   if (KEY_ADDR >= ADDR_SPAN || ARM_ADDR >= ADDR_SPAN || STAT_ADDR >= ADDR_SPAN) begin : g_chk_span
      $error("keyed_reset_guard: register address outside ADDR_W");
   end

   bus_hits_t   hits;
   logic        armed, flag, fire;
   logic [DATA_W-1:0] rd_val;

   krg_decode #(
      .ADDR_W   (ADDR_W),
      .KEY_ADDR (KEY_ADDR),
      .ARM_ADDR (ARM_ADDR),
      .STAT_ADDR(STAT_ADDR)
   ) u_decode (
      .addr_i(bus_addr),
      .wr_i  (bus_wr),
      .rd_i  (bus_rd),
      .hits_o(hits)
   );

   krg_key_seq #(
      .DATA_W    (DATA_W),
      .KEY_FIRST (KEY_FIRST),
      .KEY_SECOND(KEY_SECOND)
   ) u_key_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .hits_i      (hits),
      .wdata_i     (bus_wdata),
      .force_lock_i(fire),
      .unlocked_o  (unlocked)
   );

   krg_arm_trig u_arm_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .hits_i    (hits),
      .wbit0_i   (bus_wdata[0]),
      .unlocked_i(unlocked),
      .armed_o   (armed),
      .flag_o    (flag),
      .fire_o    (fire),
      .pulse_o   (swrst_pulse)
   );

   always_comb begin
      rd_val = '0;
      if (hits.arm_rd)  rd_val[0] = armed;
      if (hits.stat_rd) rd_val[0] = flag;
   end

   if (REG_READ) begin : g_read_registered
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rdata_q <= '0;
         else        rdata_q <= rd_val;
      end
      assign bus_rdata = rdata_q;
   end else begin : g_read_direct
      assign bus_rdata = rd_val;
   end

   // R10: while the request is high the block is locked and disarmed
   a_r10_pulse_clears_state: assert property (@(posedge clk) disable iff (!rst_n)
      swrst_pulse |-> (!unlocked && !armed));
   // R7: arm-register reads never carry bits above bit 0
   a_r7_read_width: assert property (@(posedge clk) disable iff (!rst_n)
      hits.arm_rd |-> (rd_val[DATA_W-1:1] == '0));
endmodule

// File: tb/keyed_reset_guard_tb_top.sv
`timescale 1ns/1ps
module keyed_reset_guard_tb_top;
   localparam logic [31:0] K1 = 32'hAA99_6655;
   localparam logic [31:0] K2 = 32'h5566_99AA;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        unlocked, swrst_pulse;

   int    n_chk = 0, n_bad = 0;
   bit    done = 0;
   string cur_req = "R1";

   // reference model state
   int m_state = 0;   // 0 locked, 1 first key seen, 2 open
   bit m_arm = 0, m_flag = 0, m_pulse = 0;

   always #2.5 clk = ~clk;

   keyed_reset_guard dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .unlocked(unlocked), .swrst_pulse(swrst_pulse)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_rdata();
      logic [31:0] v = '0;
      if (bus_rd && bus_addr == 4'd1) v[0] = m_arm;
      if (bus_rd && bus_addr == 4'd2) v[0] = m_flag;
      return v;
   endfunction

   // behavioural reference, stepped on every clock and compared after the edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_arm = 0; m_flag = 0; m_pulse = 0;
      end else begin
         automatic bit any  = bus_wr | bus_rd;
         automatic bit kw   = bus_wr && bus_addr == 4'd0;
         automatic bit trig = bus_rd && bus_addr == 4'd1 && m_arm;
         automatic int ns = m_state;
         automatic bit na = m_arm, nf = m_flag;
         if (trig) begin
            ns = 0; na = 0; nf = 1;
         end else begin
            if (m_state == 0 && kw) ns = (bus_wdata == K1) ? 1 : 0;
            else if (m_state == 1 && any) ns = (kw && bus_wdata == K2) ? 2 : 0;
            else if (m_state == 2 && kw) ns = 0;
            if (bus_wr && bus_addr == 4'd1 && m_state == 2) na = bus_wdata[0];
            if (bus_wr && bus_addr == 4'd2 && bus_wdata[0]) nf = 0;
         end
         m_state = ns; m_arm = na; m_flag = nf; m_pulse = trig;
      end
      #1;
      if (rst_n) begin
         check(cur_req, "unlocked", {31'b0, unlocked}, {31'b0, m_state == 2});
         check(cur_req, "swrst_pulse", {31'b0, swrst_pulse}, {31'b0, m_pulse});
      end
   end

   // one bus cycle: 0 idle, 1 write, 2 read
   task automatic op(input int kind, input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = (kind == 1); bus_rd = (kind == 2); bus_addr = a; bus_wdata = d;
      #1;
      check(cur_req, "rdata", bus_rdata, exp_rdata());
   endtask

   task automatic idle();
      op(0, 4'd0, 32'd0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bus_wr = 0; bus_rd = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      finish_run();
   end

   initial begin
      do_reset();
      // R1: reset state
      cur_req = "R1";
      idle(); idle();
      check("R1", "unlocked", {31'b0, unlocked}, 32'd0);
      op(2, 4'd1, 0); op(2, 4'd2, 0); op(2, 4'd7, 0);

      // R6: arming ignored while locked
      cur_req = "R6";
      op(1, 4'd1, 32'd1); op(2, 4'd1, 0); idle();
      check("R6", "swrst_pulse", {31'b0, swrst_pulse}, 32'd0);

      // R2: junk key, first key, idle gap, second key
      cur_req = "R2";
      op(1, 4'd0, 32'h1234_5678); op(1, 4'd0, K1); idle(); op(1, 4'd0, K2); idle();
      check("R2", "unlocked", {31'b0, unlocked}, 32'd1);

      // R9: unarmed read is quiet; R7: arm load and clear
      cur_req = "R9";
      op(2, 4'd1, 0); idle();
      check("R9", "swrst_pulse", {31'b0, swrst_pulse}, 32'd0);
      cur_req = "R7";
      op(1, 4'd1, 32'hFFFF_FFFE); op(1, 4'd1, 32'd1); op(1, 4'd1, 32'd0); op(2, 4'd1, 0);
      op(1, 4'd1, 32'd3);

      // R8: armed read fires a one-cycle request on the next cycle
      cur_req = "R8";
      op(2, 4'd1, 0);
      check("R8", "rdata", bus_rdata, 32'd1);
      idle();
      check("R8", "swrst_pulse", {31'b0, swrst_pulse}, 32'd1);
      // R10: cleared arm and lock
      check("R10", "unlocked", {31'b0, unlocked}, 32'd0);
      idle();
      check("R8", "swrst_pulse", {31'b0, swrst_pulse}, 32'd0);
      cur_req = "R10";
      op(2, 4'd1, 0);

      // R11: flag set, write 0 keeps, write 1 clears
      cur_req = "R11";
      op(2, 4'd2, 0);
      check("R11", "flag", bus_rdata, 32'd1);
      op(1, 4'd2, 32'd0); op(2, 4'd2, 0); op(1, 4'd2, 32'd1); op(2, 4'd2, 0);

      // R3: wrong keys
      cur_req = "R3";
      op(1, 4'd0, K1); op(1, 4'd0, 32'hDEAD_BEEF); op(1, 4'd0, K2); idle();
      op(1, 4'd0, K2); op(1, 4'd0, K1); op(1, 4'd0, K1); op(1, 4'd0, K2); idle();
      check("R3", "unlocked", {31'b0, unlocked}, 32'd0);

      // R4: intervening accesses break the sequence
      cur_req = "R4";
      op(1, 4'd0, K1); op(2, 4'd2, 0); op(1, 4'd0, K2); idle();
      op(1, 4'd0, K1); op(1, 4'd1, 32'd1); op(1, 4'd0, K2); op(2, 4'd1, 0);
      op(1, 4'd0, K1); op(2, 4'd0, 0); op(1, 4'd0, K2); idle();
      check("R4", "unlocked", {31'b0, unlocked}, 32'd0);

      // R5: key writes relock
      cur_req = "R5";
      op(1, 4'd0, K1); op(1, 4'd0, K2); op(1, 4'd0, K1); idle();
      check("R5", "unlocked", {31'b0, unlocked}, 32'd0);
      op(1, 4'd0, K1); op(1, 4'd0, K2); op(1, 4'd0, 32'd0); op(1, 4'd0, K2); idle();

      // R1: reset clears an armed, open block
      cur_req = "R1";
      op(1, 4'd0, K1); op(1, 4'd0, K2); op(1, 4'd1, 32'd1); idle();
      do_reset();
      idle();
      check("R1", "unlocked", {31'b0, unlocked}, 32'd0);
      op(2, 4'd1, 0); idle(); op(2, 4'd2, 0); idle();
      check("R1", "swrst_pulse", {31'b0, swrst_pulse}, 32'd0);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule